// File: doc/BRIEF.md
# Thread-Context Fork Allocator

This block keeps the control state of every hardware thread context in a small multithreaded core. For each context it stores:

- the virtual processor it is bound to;
- the flags that say whether it may be allocated, is halted, or is activated;
- a run-state, a delay-slot flag, a dirty flag, a privilege mode and an address-space ID;
- a restart PC and a three-stage PC sequence (current, next, next-next);
- one written destination register, kept as an index and a value.

A fork request names the requesting context. The block searches for a free context on the same virtual processor, claims the first one it finds and starts it. The new context inherits the requester's privilege mode and address space. If no context qualifies, the block records a coded thread exception instead.

Three more commands act on single contexts:

- **Halt** parks an active context and records its resume address.
- **Restore** restarts an inactive context from that address.
- **Bind** sets a context's virtual-processor binding, allocatable flag, delay-slot flag and address-space ID.

A peek port returns the full state of any one context combinationally. A fork result comes back as a one-cycle pulse on the clock edge after the request.

Top module: `tcf_alloc`

## Requirements
- R1: After reset, context 0 has activated=1, allocatable=0 and run-state 0. Every other context has allocatable=1, activated=0, halt=0 and run-state 1 (idle). All contexts start with binding 0, delay-slot 0, dirty 0, mode 0, ASID 0, and restart, PC and register values of 0. The exception cause reads 0 and rsp_valid is low. peek_stat is laid out as {vp[20:17], allocatable[16], halt[15], activated[14], run_state[13:12], delay_slot[11], dirty[10], mode[9:8], asid[7:0]}.
- R2: A fork considers only contexts 0 through cfg_last_ctx, which is cfg_last_ctx+1 contexts. A context above that index is never claimed.
- R3: A context qualifies for a fork only when all of the following hold: its binding equals the requesting context's binding, allocatable=1, halt=0 and activated=0.
- R4: The lowest-numbered qualifying context is claimed, and at most one context is claimed per request.
- R5: In the claimed context, the restart PC takes fork_op_pc. The written-register index takes fork_rd and its value takes fork_op_val.
- R6: The claimed context's status is rewritten in one step:
  - run-state becomes 0 (running);
  - delay-slot becomes 0, dirty becomes 1 and activated becomes 1;
  - mode becomes fork_mode;
  - ASID becomes the requesting context's ASID.
- R7: Each fork request produces exactly one rsp_valid pulse, in the cycle after the request. rsp_ctx gives the claimed index when rsp_fault=0.
- R8: When no context qualifies, rsp_fault=1, the exception cause is set to code 1, and no context's state changes.
- R9: Halting an active context clears activated, sets halt and loads the restart PC with halt_next_pc. A halt aimed at an inactive context has no effect.
- R10: Restoring an inactive context loads PC, next PC and next-next PC with restart, restart+4 and restart+8. It also sets activated and clears halt. A restore aimed at an active context has no effect.
- R11: A bind command writes the context's binding, allocatable flag, delay-slot flag and ASID, and leaves its other fields unchanged.
- R12: Only one command acts per cycle, with priority fork > halt > restore > bind. A lower-priority command issued together with a higher one is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_last_ctx | input | 3 | Highest context index a fork may scan |
| fork_req | input | 1 | Fork strobe, one cycle |
| fork_ctx | input | 3 | Requesting context |
| fork_mode | input | 2 | Requester's global privilege mode |
| fork_op_pc | input | 32 | First fork operand (restart PC) |
| fork_op_val | input | 32 | Second fork operand (register value) |
| fork_rd | input | 5 | Destination register index |
| halt_req | input | 1 | Halt strobe |
| halt_ctx | input | 3 | Context to halt |
| halt_next_pc | input | 32 | Next PC of the halting context |
| rest_req | input | 1 | Restore strobe |
| rest_ctx | input | 3 | Context to restore |
| bind_req | input | 1 | Bind strobe |
| bind_ctx | input | 3 | Context to bind |
| bind_vp | input | 4 | Virtual processor to bind |
| bind_alloc | input | 1 | Allocatable flag value |
| bind_ds | input | 1 | Delay-slot flag value |
| bind_asid | input | 8 | ASID value |
| rsp_valid | output | 1 | Fork result pulse |
| rsp_fault | output | 1 | Fork found no free context |
| rsp_ctx | output | 3 | Claimed context index |
| exc_cause | output | 3 | Virtual-processor exception cause |
| peek_ctx | input | 3 | Context selected for observation |
| peek_stat | output | 21 | Status of the selected context (layout in R1) |
| peek_restart | output | 32 | Restart PC |
| peek_pc | output | 32 | Current PC |
| peek_npc | output | 32 | Next PC |
| peek_nnpc | output | 32 | Next-next PC |
| peek_rd | output | 5 | Written register index |
| peek_val | output | 32 | Written register value |

## Verification
The hardest case to reach is a fork that fails while free-looking contexts still exist. Every context has to be excluded for a different reason: a binding mismatch, a cleared allocatable flag, a set halt flag, or an index past the scan limit. The stimulus gets there in stages:

1. Bind commands rebind some contexts and clear the allocatable flag on others.
2. Earlier forks activate further contexts.
3. A halt puts one claimed context into the halted-but-inactive state.
4. The scan limit is lowered so the last idle context falls outside it.

A later fork from a requester on the other virtual processor, issued together with a halt, covers ASID inheritance and command priority.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  localparam int VP_W    = 4;
  localparam int RS_W    = 2;
  localparam int MODE_W  = 2;
  localparam int ASID_W  = 8;
  localparam int CAUSE_W = 3;

  localparam logic [RS_W-1:0]    RS_RUN       = 2'd0;
  localparam logic [RS_W-1:0]    RS_IDLE      = 2'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_NOFREE = 3'd1;

  typedef struct packed {
    logic [VP_W-1:0]   vp;
    logic              alloc;
    logic              halt;
    logic              act;
    logic [RS_W-1:0]   rs;
    logic              ds;
    logic              dirty;
    logic [MODE_W-1:0] mode;
    logic [ASID_W-1:0] asid;
  } ctx_stat_t;

  localparam int STAT_W = $bits(ctx_stat_t);
endpackage

// File: rtl/tcf_scan.sv
module tcf_scan #(
  parameter int NCTX = 8,
  parameter int IW   = 3,
  parameter int VP_W = 4
) (
  input  logic [IW-1:0]              last_idx,
  input  logic [VP_W-1:0]            req_vp,
  input  logic [NCTX-1:0][VP_W-1:0]  vp_vec,
  input  logic [NCTX-1:0]            avail,
  output logic                       hit,
  output logic [IW-1:0]              hit_idx,
  output logic [NCTX-1:0]            first
);
  logic [NCTX-1:0] qual;
  logic [NCTX:0]   lower;

  assign lower[0] = 1'b0;

  for (genvar i = 0; i < NCTX; i++) begin : g_q
    assign qual[i]    = (IW'(i) <= last_idx) && (vp_vec[i] == req_vp) && avail[i];
    assign first[i]   = qual[i] & ~lower[i];
    assign lower[i+1] = lower[i] | qual[i];
  end

  assign hit = lower[NCTX];

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NCTX; i++) begin
      if (first[i]) hit_idx = IW'(i);
    end
  end
endmodule

// File: rtl/tcf_ctx_slot.sv
module tcf_ctx_slot
  import tcf_pkg::*;
#(
  parameter int   PC_W    = 32,
  parameter int   DATA_W  = 32,
  parameter int   RI_W    = 5,
  parameter logic RST_ACT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim,
  input  logic [PC_W-1:0]   claim_pc,
  input  logic [RI_W-1:0]   claim_rd,
  input  logic [DATA_W-1:0] claim_val,
  input  logic [MODE_W-1:0] claim_mode,
  input  logic [ASID_W-1:0] claim_asid,
  input  logic              halt_hit,
  input  logic [PC_W-1:0]   halt_pc,
  input  logic              rest_hit,
  input  logic              bind_hit,
  input  logic [VP_W-1:0]   bind_vp,
  input  logic              bind_alloc,
  input  logic              bind_ds,
  input  logic [ASID_W-1:0] bind_asid,
  output ctx_stat_t         stat,
  output logic              avail,
  output logic [PC_W-1:0]   restart,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   npc,
  output logic [PC_W-1:0]   nnpc,
  output logic [RI_W-1:0]   rd,
  output logic [DATA_W-1:0] val
);
  ctx_stat_t         stat_q, stat_d;
  logic [PC_W-1:0]   restart_q, restart_d, pc_q, pc_d, npc_q, npc_d, nnpc_q, nnpc_d;
  logic [RI_W-1:0]   rd_q, rd_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic              en;
  ctx_stat_t         stat_rst;

  always_comb begin
    stat_rst       = '0;
    stat_rst.act   = RST_ACT;
    stat_rst.alloc = ~RST_ACT;
    stat_rst.rs    = RST_ACT ? RS_RUN : RS_IDLE;
  end

  always_comb begin
    stat_d    = stat_q;
    restart_d = restart_q;
    pc_d      = pc_q;
    npc_d     = npc_q;
    nnpc_d    = nnpc_q;
    rd_d      = rd_q;
    val_d     = val_q;
    en        = 1'b0;
    if (claim) begin
      en           = 1'b1;
      restart_d    = claim_pc;
      rd_d         = claim_rd;
      val_d        = claim_val;
      stat_d.rs    = RS_RUN;
      stat_d.ds    = 1'b0;
      stat_d.dirty = 1'b1;
      stat_d.act   = 1'b1;
      stat_d.mode  = claim_mode;
      stat_d.asid  = claim_asid;
    end else if (halt_hit && stat_q.act) begin
      en          = 1'b1;
      restart_d   = halt_pc;
      stat_d.act  = 1'b0;
      stat_d.halt = 1'b1;
    end else if (rest_hit && !stat_q.act) begin
      en          = 1'b1;
      pc_d        = restart_q;
      npc_d       = restart_q + PC_W'(4);
      nnpc_d      = restart_q + PC_W'(8);
      stat_d.act  = 1'b1;
      stat_d.halt = 1'b0;
    end else if (bind_hit) begin
      en           = 1'b1;
      stat_d.vp    = bind_vp;
      stat_d.alloc = bind_alloc;
      stat_d.ds    = bind_ds;
      stat_d.asid  = bind_asid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= stat_rst;
      restart_q <= '0;
      pc_q      <= '0;
      npc_q     <= '0;
      nnpc_q    <= '0;
      rd_q      <= '0;
      val_q     <= '0;
    end else if (en) begin
      stat_q    <= stat_d;
      restart_q <= restart_d;
      pc_q      <= pc_d;
      npc_q     <= npc_d;
      nnpc_q    <= nnpc_d;
      rd_q      <= rd_d;
      val_q     <= val_d;
    end
  end

  assign stat    = stat_q;
  assign avail   = stat_q.alloc & ~stat_q.halt & ~stat_q.act;
  assign restart = restart_q;
  assign pc      = pc_q;
  assign npc     = npc_q;
  assign nnpc    = nnpc_q;
  assign rd      = rd_q;
  assign val     = val_q;

  assert_halt_records_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_hit && !claim && stat_q.act) |=> (restart_q == $past(halt_pc) && !stat_q.act && stat_q.halt));

  assert_halt_idle_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_hit && !claim && !stat_q.act) |=> $stable(stat_q) && $stable(restart_q));

  assert_restore_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rest_hit && !claim && !halt_hit && !stat_q.act) |=>
      (npc_q == pc_q + PC_W'(4) && nnpc_q == pc_q + PC_W'(8) && stat_q.act && !stat_q.halt));

  assert_claim_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> (stat_q.act && stat_q.dirty && !stat_q.ds && stat_q.rs == RS_RUN
               && stat_q.asid == $past(claim_asid)));
endmodule

// File: rtl/tcf_alloc.sv
module tcf_alloc
  import tcf_pkg::*;
#(
  parameter int NCTX   = 8,
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int RI_W   = 5,
  localparam int IW    = $clog2(NCTX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IW-1:0]        cfg_last_ctx,
  input  logic                 fork_req,
  input  logic [IW-1:0]        fork_ctx,
  input  logic [MODE_W-1:0]    fork_mode,
  input  logic [PC_W-1:0]      fork_op_pc,
  input  logic [DATA_W-1:0]    fork_op_val,
  input  logic [RI_W-1:0]      fork_rd,
  input  logic                 halt_req,
  input  logic [IW-1:0]        halt_ctx,
  input  logic [PC_W-1:0]      halt_next_pc,
  input  logic                 rest_req,
  input  logic [IW-1:0]        rest_ctx,
  input  logic                 bind_req,
  input  logic [IW-1:0]        bind_ctx,
  input  logic [VP_W-1:0]      bind_vp,
  input  logic                 bind_alloc,
  input  logic                 bind_ds,
  input  logic [ASID_W-1:0]    bind_asid,
  output logic                 rsp_valid,
  output logic                 rsp_fault,
  output logic [IW-1:0]        rsp_ctx,
  output logic [CAUSE_W-1:0]   exc_cause,
  input  logic [IW-1:0]        peek_ctx,
  output logic [STAT_W-1:0]    peek_stat,
  output logic [PC_W-1:0]      peek_restart,
  output logic [PC_W-1:0]      peek_pc,
  output logic [PC_W-1:0]      peek_npc,
  output logic [PC_W-1:0]      peek_nnpc,
  output logic [RI_W-1:0]      peek_rd,
  output logic [DATA_W-1:0]    peek_val
);
  ctx_stat_t [NCTX-1:0]            stat_vec;
  logic [NCTX-1:0][VP_W-1:0]       vp_vec;
  logic [NCTX-1:0]                 avail;
  logic [NCTX-1:0]                 first;
  logic [NCTX-1:0]                 claim_vec;
  logic [NCTX-1:0][PC_W-1:0]       restart_vec, pc_vec, npc_vec, nnpc_vec;
  logic [NCTX-1:0][RI_W-1:0]       rd_vec;
  logic [NCTX-1:0][DATA_W-1:0]     val_vec;
  logic                            hit;
  logic [IW-1:0]                   hit_idx;
  logic                            fork_go, halt_go, rest_go, bind_go;
  logic [VP_W-1:0]                 req_vp;
  logic [ASID_W-1:0]               req_asid;

  logic                            rsp_valid_q, rsp_valid_d;
  logic                            rsp_fault_q, rsp_fault_d;
  logic [IW-1:0]                   rsp_ctx_q, rsp_ctx_d;
  logic [CAUSE_W-1:0]              cause_q, cause_d;
  logic                            rsp_en;

  // one command per cycle: fork > halt > restore > bind
  assign fork_go = fork_req;
  assign halt_go = halt_req & ~fork_req;
  assign rest_go = rest_req & ~fork_req & ~halt_req;
  assign bind_go = bind_req & ~fork_req & ~halt_req & ~rest_req;

  assign req_vp   = stat_vec[fork_ctx].vp;
  assign req_asid = stat_vec[fork_ctx].asid;

  tcf_scan #(.NCTX(NCTX), .IW(IW), .VP_W(VP_W)) u_scan (
    .last_idx (cfg_last_ctx),
    .req_vp   (req_vp),
    .vp_vec   (vp_vec),
    .avail    (avail),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .first    (first)
  );

  assign claim_vec = first & {NCTX{fork_go}};

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    tcf_ctx_slot #(
      .PC_W    (PC_W),
      .DATA_W  (DATA_W),
      .RI_W    (RI_W),
      .RST_ACT (i == 0)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .claim      (claim_vec[i]),
      .claim_pc   (fork_op_pc),
      .claim_rd   (fork_rd),
      .claim_val  (fork_op_val),
      .claim_mode (fork_mode),
      .claim_asid (req_asid),
      .halt_hit   (halt_go && halt_ctx == IW'(i)),
      .halt_pc    (halt_next_pc),
      .rest_hit   (rest_go && rest_ctx == IW'(i)),
      .bind_hit   (bind_go && bind_ctx == IW'(i)),
      .bind_vp    (bind_vp),
      .bind_alloc (bind_alloc),
      .bind_ds    (bind_ds),
      .bind_asid  (bind_asid),
      .stat       (stat_vec[i]),
      .avail      (avail[i]),
      .restart    (restart_vec[i]),
      .pc         (pc_vec[i]),
      .npc        (npc_vec[i]),
      .nnpc       (nnpc_vec[i]),
      .rd         (rd_vec[i]),
      .val        (val_vec[i])
    );
    assign vp_vec[i] = stat_vec[i].vp;
  end

  always_comb begin
    rsp_valid_d = fork_go;
    rsp_fault_d = fork_go & ~hit;
    rsp_ctx_d   = rsp_ctx_q;
    cause_d     = cause_q;
    rsp_en      = fork_go | rsp_valid_q;
    if (fork_go) begin
      rsp_ctx_d = hit ? hit_idx : '0;
      if (!hit) cause_d = CAUSE_NOFREE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_ctx_q   <= '0;
      cause_q     <= '0;
    end else if (rsp_en) begin
      rsp_valid_q <= rsp_valid_d;
      rsp_fault_q <= rsp_fault_d;
      rsp_ctx_q   <= rsp_ctx_d;
      cause_q     <= cause_d;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_fault    = rsp_fault_q;
  assign rsp_ctx      = rsp_ctx_q;
  assign exc_cause    = cause_q;
  assign peek_stat    = stat_vec[peek_ctx];
  assign peek_restart = restart_vec[peek_ctx];
  assign peek_pc      = pc_vec[peek_ctx];
  assign peek_npc     = npc_vec[peek_ctx];
  assign peek_nnpc    = nnpc_vec[peek_ctx];
  assign peek_rd      = rd_vec[peek_ctx];
  assign peek_val     = val_vec[peek_ctx];

  assert_single_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec));

  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fork_req |=> rsp_valid);

  assert_rsp_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fork_req |=> !rsp_valid);

  assert_scan_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fork_req && hit) |=> (rsp_ctx <= $past(cfg_last_ctx)));

  assert_fault_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (exc_cause == CAUSE_NOFREE));

  assert_fault_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fork_req && !hit) |=> $stable(stat_vec));

  assert_claimed_binding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (stat_vec[rsp_ctx].act && stat_vec[rsp_ctx].alloc));
endmodule

// File: tb/tcf_alloc_bench.sv
module tcf_alloc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_last_ctx = 3'd7;
  logic        fork_req = 1'b0;
  logic [2:0]  fork_ctx = '0;
  logic [1:0]  fork_mode = '0;
  logic [31:0] fork_op_pc = '0;
  logic [31:0] fork_op_val = '0;
  logic [4:0]  fork_rd = '0;
  logic        halt_req = 1'b0;
  logic [2:0]  halt_ctx = '0;
  logic [31:0] halt_next_pc = '0;
  logic        rest_req = 1'b0;
  logic [2:0]  rest_ctx = '0;
  logic        bind_req = 1'b0;
  logic [2:0]  bind_ctx = '0;
  logic [3:0]  bind_vp = '0;
  logic        bind_alloc = 1'b0;
  logic        bind_ds = 1'b0;
  logic [7:0]  bind_asid = '0;
  logic [2:0]  peek_ctx = '0;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_ctx;
  logic [2:0]  exc_cause;
  logic [20:0] peek_stat;
  logic [31:0] peek_restart, peek_pc, peek_npc, peek_nnpc, peek_val;
  logic [4:0]  peek_rd;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       fault;
    logic [2:0] ctx;
    string      tag;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  tcf_alloc u_tcf_alloc (
    .clk(clk), .rst_n(rst_n), .cfg_last_ctx(cfg_last_ctx),
    .fork_req(fork_req), .fork_ctx(fork_ctx), .fork_mode(fork_mode),
    .fork_op_pc(fork_op_pc), .fork_op_val(fork_op_val), .fork_rd(fork_rd),
    .halt_req(halt_req), .halt_ctx(halt_ctx), .halt_next_pc(halt_next_pc),
    .rest_req(rest_req), .rest_ctx(rest_ctx),
    .bind_req(bind_req), .bind_ctx(bind_ctx), .bind_vp(bind_vp),
    .bind_alloc(bind_alloc), .bind_ds(bind_ds), .bind_asid(bind_asid),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_ctx(rsp_ctx),
    .exc_cause(exc_cause), .peek_ctx(peek_ctx), .peek_stat(peek_stat),
    .peek_restart(peek_restart), .peek_pc(peek_pc), .peek_npc(peek_npc),
    .peek_nnpc(peek_nnpc), .peek_rd(peek_rd), .peek_val(peek_val)
  );

  function automatic logic [20:0] mk(input logic [3:0] vp, input logic al, input logic h,
                                     input logic a, input logic [1:0] rs, input logic ds,
                                     input logic dt, input logic [1:0] md, input logic [7:0] asid);
    return {vp, al, h, a, rs, ds, dt, md, asid};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop the scoreboard whenever a result pulse appears
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) begin
        chk("R7 unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk({e.tag, " fault"}, 64'(rsp_fault), 64'(e.fault));
        if (!e.fault) chk({e.tag, " ctx"}, 64'(rsp_ctx), 64'(e.ctx));
      end
    end
  end

  task automatic do_fork(input logic [2:0] src, input logic [1:0] md, input logic [31:0] pc,
                         input logic [31:0] v, input logic [4:0] rd, input logic xf,
                         input logic [2:0] xc, input string tag,
                         input logic also_halt, input logic [2:0] hctx);
    exp_t e;
    @(negedge clk);
    fork_req = 1'b1; fork_ctx = src; fork_mode = md; fork_op_pc = pc;
    fork_op_val = v; fork_rd = rd;
    halt_req = also_halt; halt_ctx = hctx; halt_next_pc = 32'hBAD0;
    e.fault = xf; e.ctx = xc; e.tag = tag;
    expq.push_back(e);
    @(negedge clk);
    fork_req = 1'b0; halt_req = 1'b0;
  endtask

  task automatic do_bind(input logic [2:0] c, input logic [3:0] vp, input logic al,
                         input logic ds, input logic [7:0] asid);
    @(negedge clk);
    bind_req = 1'b1; bind_ctx = c; bind_vp = vp; bind_alloc = al; bind_ds = ds; bind_asid = asid;
    @(negedge clk);
    bind_req = 1'b0;
  endtask

  task automatic do_halt(input logic [2:0] c, input logic [31:0] npc);
    @(negedge clk);
    halt_req = 1'b1; halt_ctx = c; halt_next_pc = npc;
    @(negedge clk);
    halt_req = 1'b0;
  endtask

  task automatic do_rest(input logic [2:0] c);
    @(negedge clk);
    rest_req = 1'b1; rest_ctx = c;
    @(negedge clk);
    rest_req = 1'b0;
  endtask

  task automatic peek(input logic [2:0] c);
    peek_ctx = c;
    #1;
  endtask

  initial begin
    #(200000 * 10);
    chk("watchdog expired", 64'd1, 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 exc_cause", 64'(exc_cause), 64'd0);
    peek(3'd0); chk("R1 ctx0 stat", 64'(peek_stat), 64'(mk(0,0,0,1,2'd0,0,0,2'd0,8'h00)));
    peek(3'd3); chk("R1 ctx3 stat", 64'(peek_stat), 64'(mk(0,1,0,0,2'd1,0,0,2'd0,8'h00)));
    chk("R1 ctx3 restart", 64'(peek_restart), 64'd0);

    // R11 bind writes
    do_bind(3'd0, 4'd0, 1'b0, 1'b0, 8'h5A);
    do_bind(3'd2, 4'd0, 1'b1, 1'b1, 8'h00);
    peek(3'd0); chk("R11 ctx0 bind", 64'(peek_stat), 64'(mk(0,0,0,1,2'd0,0,0,2'd0,8'h5A)));
    peek(3'd2); chk("R11 ctx2 bind", 64'(peek_stat), 64'(mk(0,1,0,0,2'd1,1,0,2'd0,8'h00)));

    // R4 lowest free context first
    do_fork(3'd0, 2'd2, 32'h1000, 32'hDEAD, 5'd7, 1'b0, 3'd1, "R4 first fork", 1'b0, 3'd0);
    peek(3'd1);
    chk("R5 ctx1 restart", 64'(peek_restart), 64'h1000);
    chk("R5 ctx1 rd", 64'(peek_rd), 64'd7);
    chk("R5 ctx1 val", 64'(peek_val), 64'hDEAD);
    chk("R6 ctx1 stat", 64'(peek_stat), 64'(mk(0,1,0,1,2'd0,0,1,2'd2,8'h5A)));
    peek(3'd2); chk("R4 ctx2 untouched", 64'(peek_stat), 64'(mk(0,1,0,0,2'd1,1,0,2'd0,8'h00)));

    // R6 delay-slot cleared on claim
    do_fork(3'd0, 2'd2, 32'h1100, 32'h11, 5'd3, 1'b0, 3'd2, "R6 second fork", 1'b0, 3'd0);
    peek(3'd2); chk("R6 ctx2 stat", 64'(peek_stat), 64'(mk(0,1,0,1,2'd0,0,1,2'd2,8'h5A)));

    // R3 binding mismatch skipped, then allocatable=0 skipped
    do_bind(3'd3, 4'd1, 1'b1, 1'b0, 8'h33);
    do_fork(3'd0, 2'd1, 32'h3000, 32'h22, 5'd4, 1'b0, 3'd4, "R3 skip other vp", 1'b0, 3'd0);
    do_bind(3'd5, 4'd0, 1'b0, 1'b0, 8'h00);
    do_fork(3'd0, 2'd1, 32'h3100, 32'h33, 5'd5, 1'b0, 3'd6, "R3 skip non-allocatable", 1'b0, 3'd0);

    // R9 halt of an active context
    do_halt(3'd6, 32'h2000);
    peek(3'd6);
    chk("R9 ctx6 restart", 64'(peek_restart), 64'h2000);
    chk("R9 ctx6 stat", 64'(peek_stat), 64'(mk(0,1,1,0,2'd0,0,1,2'd1,8'h5A)));

    // R2 + R3 halted + R8: no qualifier within limit
    cfg_last_ctx = 3'd6;
    do_fork(3'd0, 2'd1, 32'h4000, 32'h44, 5'd6, 1'b1, 3'd0, "R8 no free context", 1'b0, 3'd0);
    chk("R8 exc_cause", 64'(exc_cause), 64'd1);
    peek(3'd7); chk("R8 ctx7 unchanged", 64'(peek_stat), 64'(mk(0,1,0,0,2'd1,0,0,2'd0,8'h00)));
    peek(3'd6); chk("R8 ctx6 unchanged", 64'(peek_restart), 64'h2000);

    // R2 raising the limit exposes ctx7
    cfg_last_ctx = 3'd7;
    do_fork(3'd0, 2'd1, 32'h4100, 32'h55, 5'd8, 1'b0, 3'd7, "R2 limit raised", 1'b0, 3'd0);

    // R9 halt of inactive context ignored
    do_halt(3'd3, 32'h9999);
    peek(3'd3);
    chk("R9 idle halt restart", 64'(peek_restart), 64'd0);
    chk("R9 idle halt stat", 64'(peek_stat), 64'(mk(1,1,0,0,2'd1,0,0,2'd0,8'h33)));

    // R10 restore
    do_rest(3'd6);
    peek(3'd6);
    chk("R10 pc", 64'(peek_pc), 64'h2000);
    chk("R10 npc", 64'(peek_npc), 64'h2004);
    chk("R10 nnpc", 64'(peek_nnpc), 64'h2008);
    chk("R10 stat", 64'(peek_stat), 64'(mk(0,1,0,1,2'd0,0,1,2'd1,8'h5A)));
    do_rest(3'd1);
    peek(3'd1); chk("R10 active restore ignored", 64'(peek_pc), 64'd0);

    // R12 fork with simultaneous halt: halt dropped; R3/R6 other vp and asid
    do_bind(3'd5, 4'd1, 1'b1, 1'b0, 8'h77);
    do_fork(3'd3, 2'd3, 32'h5000, 32'h66, 5'd9, 1'b0, 3'd3, "R12 fork beats halt", 1'b1, 3'd0);
    peek(3'd0); chk("R12 halt dropped", 64'(peek_stat), 64'(mk(0,0,0,1,2'd0,0,0,2'd0,8'h5A)));
    do_fork(3'd3, 2'd3, 32'h5100, 32'h77, 5'd10, 1'b0, 3'd5, "R3 same vp match", 1'b0, 3'd0);
    peek(3'd5); chk("R6 asid from requester", 64'(peek_stat), 64'(mk(1,1,0,1,2'd0,0,1,2'd3,8'h33)));
    do_fork(3'd0, 2'd0, 32'h6000, 32'h88, 5'd11, 1'b1, 3'd0, "R8 all busy", 1'b0, 3'd0);

    repeat (2) @(negedge clk);
    chk("R7 scoreboard drained", 64'(expq.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule